// File: doc/BRIEF.md
# Power-On Configuration Loader

This block brings a register bank up from power-on. The `rst_ni` input stands for the power-on reset and clears every working register. When reset is released, the block reads one fixed address window of a nonvolatile store, one word per clock. Each word goes into the same address of the working register file. The addresses below and above that window are not loaded and stay at zero.

While the copy runs, the block keeps the system in a boot state:

- fault detection on the monitored inputs is masked;
- host register access is refused;
- the output drivers are held at high impedance;
- the system reset output is held low.

When the last word has been written, the block pulses a completion strobe and leaves the boot state. It then holds reset low for a programmable number of cycles, counted while every monitored channel reports in range. It releases reset at the end of that count. The nonvolatile store is outside the block and is read through a synchronous port with a fixed latency.

Top module: `boot_loader`

## Requirements
- R1: While `rst_ni` is low, `reset_no`=0, `fault_mask_o`=1, `drive_hiz_o`=1, `acc_ready_o`=0, `boot_done_o`=0 and `rd_data_o`=0. Every register of the 128-entry file reads 0 after each reset unless it is loaded by the copy.
- R2: Addresses 0x0F to 0x7D are copied. One read is issued per cycle, in rising address order starting with 0x0F. `nvm_req_o` is high only while a window address is on `nvm_addr_o`. Read data returns RD_LAT edges after the request (default 1). Each word is written to the address it was read from.
- R3: Addresses 0x00 to 0x0E and 0x7E to 0x7F are never written by the copy. They read 0 after boot unless the host writes them.
- R4: `fault_mask_o` and `drive_hiz_o` are 1 while `acc_ready_o` is 0, and both are 0 once it is 1.
- R5: While `acc_ready_o` is 0, `host_we_i` has no effect and `rd_data_o` is 0. Once it is 1, a host write lands at the next edge and `rd_data_o` shows the addressed word combinationally.
- R6: `acc_ready_o` rises, and `boot_done_o` pulses high for exactly one cycle, on the 111+RD_LAT-th rising edge after reset release. This happens once per reset.
- R7: `reset_no` is 0 throughout boot. It rises on the (T+1)-th consecutive edge at which `acc_ready_o` and `in_range_i` were both 1, where T is `rst_tmo_i`. A cycle with `in_range_i` at 0 restarts the count. Once high, `reset_no` stays high until the next reset.
- R8: Boot completes within BOOT_BUDGET cycles. The default of 375000 cycles equals 1.5 ms at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | power-on reset, active low, asynchronous |
| nvm_req_o | output | 1 | nonvolatile read request |
| nvm_addr_o | output | 7 | nonvolatile read address |
| nvm_rdata_i | input | 8 | nonvolatile read data, RD_LAT cycles after request |
| host_we_i | input | 1 | host register write enable |
| host_addr_i | input | 7 | host write address |
| host_wdata_i | input | 8 | host write data |
| rd_addr_i | input | 7 | host read address |
| rd_data_o | output | 8 | host read data, 0 during boot |
| in_range_i | input | 1 | all monitored channels within thresholds |
| rst_tmo_i | input | 8 | reset timeout in cycles |
| fault_mask_o | output | 1 | fault detection masked |
| acc_ready_o | output | 1 | host access allowed |
| drive_hiz_o | output | 1 | output drivers held at high impedance |
| boot_done_o | output | 1 | one-cycle copy-complete strobe |
| reset_no | output | 1 | system reset, active low |

## Verification
The end of the copy and the start of the reset timeout fall on the same edge. If `in_range_i` is already high when the copy ends, the timeout must begin counting at that edge and not one cycle earlier. The bench provokes this by holding `in_range_i` high through the whole boot, with timeout values 0 and 200. It then checks the cycle at which `reset_no` rises against a cycle count it works out itself. A second collision is a channel dropping out of range on the very cycle the timeout would expire. This is driven deliberately, and the bench expects the count to restart at that cycle rather than the reset being released.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic {
    BS_COPY = 1'b0,
    BS_UP   = 1'b1
  } boot_state_e;

  localparam int unsigned DEF_AW     = 7;
  localparam int unsigned DEF_DW     = 8;
  localparam int unsigned DEF_TW     = 8;
  localparam int unsigned DEF_RD_LAT = 1;
  localparam int unsigned DEF_BUDGET = 375000;
endpackage

// File: rtl/boot_seq.sv
module boot_seq
  import boot_pkg::*;
#(
  parameter int unsigned     AW      = DEF_AW,
  parameter int unsigned     RD_LAT  = DEF_RD_LAT,
  parameter logic [AW-1:0]   COPY_LO = 'h0F,
  parameter logic [AW-1:0]   COPY_HI = 'h7D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          req_o,
  output logic [AW-1:0] req_addr_o,
  output logic          wr_vld_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          booted_o,
  output logic          done_o
);
  logic          issuing_q;
  logic [AW-1:0] issue_addr_q;
  logic [RD_LAT-1:0] vld_q;
  logic [AW-1:0]     adr_q [RD_LAT];
  boot_state_e       state_q;
  logic              last_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issuing_q    <= 1'b1;
      issue_addr_q <= COPY_LO;
    end else if (issuing_q) begin
      if (issue_addr_q == COPY_HI) issuing_q <= 1'b0;
      else issue_addr_q <= issue_addr_q + 1'b1;
    end
  end

  assign req_o      = issuing_q;
  assign req_addr_o = issue_addr_q;

  // address/valid travel alongside the memory read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < int'(RD_LAT); i++) adr_q[i] <= '0;
    end else begin
      vld_q[0] <= issuing_q;
      adr_q[0] <= issue_addr_q;
      for (int i = 1; i < int'(RD_LAT); i++) begin
        vld_q[i] <= vld_q[i-1];
        adr_q[i] <= adr_q[i-1];
      end
    end
  end

  assign wr_vld_o  = vld_q[RD_LAT-1];
  assign wr_addr_o = adr_q[RD_LAT-1];
  assign last_wr   = wr_vld_o && (wr_addr_o == COPY_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_COPY;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_wr;
      if (last_wr) state_q <= BS_UP;
    end
  end

  assign booted_o = (state_q == BS_UP);
endmodule

// File: rtl/boot_regfile.sv
module boot_regfile
  import boot_pkg::*;
#(
  parameter int unsigned AW = DEF_AW,
  parameter int unsigned DW = DEF_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/boot_rst_timer.sv
module boot_rst_timer
  import boot_pkg::*;
#(
  parameter int unsigned TW = DEF_TW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          booted_i,
  input  logic          in_range_i,
  input  logic [TW-1:0] tmo_i,
  output logic          rel_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_o <= 1'b0;
    end else if (!rel_o) begin
      if (!booted_i || !in_range_i) cnt_q <= '0;
      else if (cnt_q == tmo_i)      rel_o <= 1'b1;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int unsigned   AW          = DEF_AW,
  parameter int unsigned   DW          = DEF_DW,
  parameter int unsigned   TW          = DEF_TW,
  parameter int unsigned   RD_LAT      = DEF_RD_LAT,
  parameter int unsigned   BOOT_BUDGET = DEF_BUDGET,
  parameter logic [AW-1:0] COPY_LO     = 'h0F,
  parameter logic [AW-1:0] COPY_HI     = 'h7D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          nvm_req_o,
  output logic [AW-1:0] nvm_addr_o,
  input  logic [DW-1:0] nvm_rdata_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          in_range_i,
  input  logic [TW-1:0] rst_tmo_i,
  output logic          fault_mask_o,
  output logic          acc_ready_o,
  output logic          drive_hiz_o,
  output logic          boot_done_o,
  output logic          reset_no
);
  logic          cp_vld;
  logic [AW-1:0] cp_addr;
  logic          booted;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] rf_rdata;

  boot_seq #(
    .AW(AW), .RD_LAT(RD_LAT), .COPY_LO(COPY_LO), .COPY_HI(COPY_HI)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_o      (nvm_req_o),
    .req_addr_o (nvm_addr_o),
    .wr_vld_o   (cp_vld),
    .wr_addr_o  (cp_addr),
    .booted_o   (booted),
    .done_o     (boot_done_o)
  );

  // copy owns the write port; host writes only once booted
  always_comb begin
    rf_we    = cp_vld | (host_we_i & booted);
    rf_waddr = cp_vld ? cp_addr     : host_addr_i;
    rf_wdata = cp_vld ? nvm_rdata_i : host_wdata_i;
  end

  boot_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rf_rdata)
  );

  boot_rst_timer #(.TW(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .booted_i   (booted),
    .in_range_i (in_range_i),
    .tmo_i      (rst_tmo_i),
    .rel_o      (reset_no)
  );

  assign acc_ready_o  = booted;
  assign fault_mask_o = ~booted;
  assign drive_hiz_o  = ~booted;
  assign rd_data_o    = booted ? rf_rdata : '0;
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int unsigned   AW          = 7,
  parameter int unsigned   BOOT_BUDGET = 375000,
  parameter logic [AW-1:0] COPY_LO     = 'h0F,
  parameter logic [AW-1:0] COPY_HI     = 'h7D
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          nvm_req_o,
  input logic [AW-1:0] nvm_addr_o,
  input logic          in_range_i,
  input logic          fault_mask_o,
  input logic          acc_ready_o,
  input logic          drive_hiz_o,
  input logic          boot_done_o,
  input logic          reset_no
);
  logic [31:0] boot_cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_cyc_q <= '0;
    else if (!acc_ready_o && boot_cyc_q != '1) boot_cyc_q <= boot_cyc_q + 1;
  end

  assert_req_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_req_o |-> (nvm_addr_o >= COPY_LO && nvm_addr_o <= COPY_HI));

  assert_req_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nvm_req_o && nvm_addr_o != COPY_HI) |=> (nvm_req_o && nvm_addr_o == $past(nvm_addr_o) + 1'b1));

  assert_boot_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |-> (fault_mask_o && drive_hiz_o));

  assert_ready_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ready_o |-> (!fault_mask_o && !drive_hiz_o && !nvm_req_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> !boot_done_o);

  assert_done_with_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_ready_o) |-> boot_done_o);

  assert_ready_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ready_o |=> acc_ready_o);

  assert_rst_low_boot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |-> !reset_no);

  assert_rst_needs_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_no) |-> $past(in_range_i));

  assert_rst_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_no |=> reset_no);

  assert_budget_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_cyc_q < 32'(BOOT_BUDGET));
endmodule

bind boot_loader boot_loader_chk #(
  .AW(AW), .BOOT_BUDGET(BOOT_BUDGET), .COPY_LO(COPY_LO), .COPY_HI(COPY_HI)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nvm_req_o    (nvm_req_o),
  .nvm_addr_o   (nvm_addr_o),
  .in_range_i   (in_range_i),
  .fault_mask_o (fault_mask_o),
  .acc_ready_o  (acc_ready_o),
  .drive_hiz_o  (drive_hiz_o),
  .boot_done_o  (boot_done_o),
  .reset_no     (reset_no)
);

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
  localparam int AW     = 7;
  localparam int DW     = 8;
  localparam int TW     = 8;
  localparam int RD_LAT = 1;
  localparam int BUDGET = 375000;
  localparam int LO     = 'h0F;
  localparam int HI     = 'h7D;
  localparam int NCOPY  = HI - LO + 1;
  localparam int T_BOOT = NCOPY + RD_LAT;
  localparam int EP_LEN = T_BOOT + 128 + 220;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          nvm_req;
  logic [AW-1:0] nvm_addr;
  logic [DW-1:0] nvm_rdata;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          in_range = 1'b0;
  logic [TW-1:0] tmo = '0;
  logic          fault_mask, acc_ready, drive_hiz, boot_done, reset_n;

  logic [DW-1:0] mem [128];
  logic [DW-1:0] shadow [128];
  logic [DW-1:0] rd_pipe [RD_LAT];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (nvm_req) rd_pipe[0] <= mem[nvm_addr];
    for (int i = 1; i < RD_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
  end
  assign nvm_rdata = rd_pipe[RD_LAT-1];

  boot_loader #(.RD_LAT(RD_LAT), .BOOT_BUDGET(BUDGET)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .nvm_req_o    (nvm_req),
    .nvm_addr_o   (nvm_addr),
    .nvm_rdata_i  (nvm_rdata),
    .host_we_i    (host_we),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .in_range_i   (in_range),
    .rst_tmo_i    (tmo),
    .fault_mask_o (fault_mask),
    .acc_ready_o  (acc_ready),
    .drive_hiz_o  (drive_hiz),
    .boot_done_o  (boot_done),
    .reset_no     (reset_n)
  );

  function automatic bit in_window(int a);
    return (a >= LO) && (a <= HI);
  endfunction

  function automatic string addr_req(int a);
    return in_window(a) ? "R2" : "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      summary();
    end
  end

  // mode 0: in range all along; 1: random; 2: late in range plus drop at expiry
  task automatic episode(input int t_val, input int mode);
    int  c, run;
    bit  exp_rel, exp_rdy, pend, dropped;
    int  pend_a, pend_d, done_cnt;
    rst_ni   = 1'b0;
    host_we  = 1'b0;
    in_range = 1'b0;
    tmo      = TW'(t_val);
    for (int a = 0; a < 128; a++) begin
      mem[a]    = DW'($urandom);
      shadow[a] = '0;
    end
    repeat (3) @(negedge clk);
    rd_addr = AW'($urandom);
    #1;
    chk(reset_n == 1'b0,    "R1", "reset_no in por",     int'(reset_n),    0);
    chk(fault_mask == 1'b1, "R1", "fault_mask in por",   int'(fault_mask), 1);
    chk(drive_hiz == 1'b1,  "R1", "drive_hiz in por",    int'(drive_hiz),  1);
    chk(acc_ready == 1'b0,  "R1", "acc_ready in por",    int'(acc_ready),  0);
    chk(boot_done == 1'b0,  "R1", "boot_done in por",    int'(boot_done),  0);
    chk(rd_data == '0,      "R1", "rd_data in por",      int'(rd_data),    0);
    rst_ni = 1'b1;
    c = 0; run = 0; exp_rel = 1'b0; pend = 1'b0; dropped = 1'b0; done_cnt = 0;
    in_range = (mode == 0);
    for (int k = 0; k < EP_LEN; k++) begin
      @(negedge clk);
      c++;
      exp_rdy = (c >= T_BOOT);
      if (c == T_BOOT)
        for (int a = LO; a <= HI; a++) shadow[a] = mem[a];
      if (pend) shadow[pend_a] = DW'(pend_d);
      if (boot_done) done_cnt++;
      chk(acc_ready == exp_rdy,     "R6", "acc_ready",  int'(acc_ready),  int'(exp_rdy));
      chk(boot_done == (c == T_BOOT), "R6", "boot_done", int'(boot_done), int'(c == T_BOOT));
      chk(fault_mask == !acc_ready, "R4", "fault_mask", int'(fault_mask), int'(!acc_ready));
      chk(drive_hiz == !acc_ready,  "R4", "drive_hiz",  int'(drive_hiz),  int'(!acc_ready));
      chk(reset_n == exp_rel,       "R7", "reset_no",   int'(reset_n),    int'(exp_rel));
      if (c == T_BOOT)
        chk(c <= BUDGET, "R8", "boot cycles", c, BUDGET);
      // stimulus for the next edge
      case (mode)
        0: in_range = 1'b1;
        1: in_range = ($urandom % 10) != 0;
        default: begin
          in_range = (c > T_BOOT + 130);
          if (in_range && !dropped && run == t_val) begin
            in_range = 1'b0;
            dropped  = 1'b1;
          end
        end
      endcase
      if (c >= T_BOOT && c < T_BOOT + 128) begin
        host_we = 1'b0;
        rd_addr = AW'(c - T_BOOT);
      end else begin
        host_we    = ($urandom % 3) == 0;
        host_addr  = AW'($urandom);
        host_wdata = DW'($urandom);
        rd_addr    = ($urandom % 2) ? host_addr : AW'($urandom);
      end
      #1;
      if (!exp_rdy)
        chk(rd_data == '0, "R5", "rd_data during boot", int'(rd_data), 0);
      else if (c < T_BOOT + 128)
        chk(rd_data == shadow[rd_addr], addr_req(int'(rd_addr)), "copied word",
            int'(rd_data), int'(shadow[rd_addr]));
      else
        chk(rd_data == shadow[rd_addr], "R5", "host read", int'(rd_data), int'(shadow[rd_addr]));
      pend   = exp_rdy && host_we;
      pend_a = int'(host_addr);
      pend_d = int'(host_wdata);
      if (!exp_rel) begin
        if (exp_rdy && in_range) begin
          run++;
          if (run == t_val + 1) exp_rel = 1'b1;
        end else run = 0;
      end
    end
    chk(done_cnt == 1, "R6", "boot_done pulses", done_cnt, 1);
    if (mode != 1)
      chk(exp_rel == 1'b1, "R7", "reset released in episode", int'(exp_rel), 1);
    if (mode == 2)
      chk(dropped == 1'b1, "R7", "drop at expiry driven", int'(dropped), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_b007));
    episode(0, 0);
    episode(5, 2);
    episode(int'($urandom % 30), 1);
    episode(200, 0);
    episode(3, 1);
    finished = 1'b1;
    summary();
  end
endmodule